// File: doc/BRIEF.md
# Chip Select Strobe Timing Generator

This block sits inside an SPI master next to the transfer sequencer. At the start of a transfer it captures a 7-bit encoded chip-select code and drives it onto the select lines. It waits a programmable lead time and then pulls an active-low strobe. An external demultiplexer uses the strobe to decode the code into one of up to 128 selects. Because the strobe is only low while the code is settled, the decoded selects stay free of glitches.

When the strobe is asserted, the block raises a ready flag so that the sequencer can begin clocking data. When the sequencer signals the end of the transfer, the strobe is released first. After a second programmable lag time the select lines are released, and a one-cycle completion pulse goes back to the sequencer. One down-counter times both delays. The strobe is only allowed in master mode with the strobe enable set and continuous clock mode off; otherwise the timing still runs but the strobe stays high.

Top module: `cs_strobe_gen`

## Requirements
- R1: Out of reset, strobe_n is 1, cs_active is 0, cs_code_out is 0, strobe_ready is 0 and release_done is 0.
- R2: A high xfer_start sampled while idle makes cs_active 1 and cs_code_out equal to the sampled cs_code_in from the next cycle on.
- R3: strobe_n falls and strobe_ready rises exactly N cycles after cs_active rises. N is decoded from lead_sel sampled at start as 2'b00→1, 2'b01→3, 2'b10→5, 2'b11→7.
- R4: A high xfer_stop sampled while strobe_ready is 1 returns strobe_n to 1 and strobe_ready to 0 in the next cycle. cs_active then falls M cycles later, with M decoded from lag_sel sampled at start using the same table as R3.
- R5: release_done is 1 for exactly one cycle, the cycle in which cs_active falls, and cs_code_out returns to 0 in that cycle.
- R6: cs_code_out does not change while cs_active stays 1, whatever cs_code_in does.
- R7: strobe_n stays 1 for a whole transfer unless master_mode=1, strobe_en=1 and cont_clk=0 were all sampled at start. The cs_active and strobe_ready timing is the same either way.
- R8: xfer_start is ignored while a transfer is in progress, and xfer_stop is ignored before strobe_ready is 1.
- R9: strobe_n is never 0 while cs_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Sequencer request to open a transfer |
| xfer_stop | input | 1 | Sequencer request to close the transfer |
| cs_code_in | input | 7 | Encoded chip-select code for the next transfer |
| lead_sel | input | 2 | Lead delay prescaler field |
| lag_sel | input | 2 | Lag delay prescaler field |
| strobe_en | input | 1 | Strobe enable |
| master_mode | input | 1 | Block is operating as master |
| cont_clk | input | 1 | Continuous serial clock mode active |
| cs_code_out | output | 7 | Chip-select code driven to the select lines |
| cs_active | output | 1 | Select lines are asserted |
| strobe_n | output | 1 | Active-low strobe for the external decoder |
| strobe_ready | output | 1 | Sequencer may clock data |
| release_done | output | 1 | One-cycle pulse when the selects are released |

## Verification
The bench measures both delays cycle by cycle for every prescaler value, including the 1-cycle minimum. A counter that is off by one would shift the strobe edge or the release edge by a cycle. While a transfer is open, the bench changes cs_code_in and pulses both handshake inputs out of turn. A design that re-latched the code or accepted an early stop would show a changed code or a short strobe. Transfers run with each of the three gating inputs cleared in turn, to catch a strobe that leaks out in slave or continuous-clock mode. The bench also checks that the completion pulse lasts one cycle and lines up with the release edge.

// File: rtl/cssg_pkg.sv
package cssg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LEAD   = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_LAG    = 2'd3
   } cssg_state_e;

   // Odd-step prescaler: field value k selects 2k+1 system clock cycles.
   function automatic int unsigned cssg_delay_len(input int unsigned k);
      return 2 * k + 1;
   endfunction

endpackage

// File: rtl/cssg_sel_decode.sv
module cssg_sel_decode #(
   parameter int SEL_W = 2,
   parameter int CNT_W = SEL_W + 1,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] reload
);
   import cssg_pkg::*;

   initial begin
      assert (CNT_W >= SEL_W + 1)
         else $error("cssg_sel_decode: CNT_W too narrow for SEL_W");
   end

   generate
      if (USE_TABLE && SEL_W == 2) begin : g_table
         // reload value is the delay length minus one
         always_comb begin
            case (sel)
               2'b00:   reload = CNT_W'(0);
               2'b01:   reload = CNT_W'(2);
               2'b10:   reload = CNT_W'(4);
               default: reload = CNT_W'(6);
            endcase
         end
      end else begin : g_arith
         always_comb begin
            reload = CNT_W'(cssg_delay_len(int'(sel)) - 1);
         end
      end
   endgenerate

endmodule

// File: rtl/cssg_down_counter.sv
module cssg_down_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero); // R3

endmodule

// File: rtl/cssg_seq_fsm.sv
module cssg_seq_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic cnt_zero,
   input  logic gate,
   output logic ld_lead,
   output logic ld_lag,
   output logic dec,
   output logic capture,
   output logic finish,
   output logic cs_active,
   output logic strobe_n,
   output logic ready,
   output logic done
);
   import cssg_pkg::*;

   cssg_state_e st_q, st_d;
   logic        cs_q, strobe_on_q, ready_q, done_q;

   always_comb begin
      st_d    = st_q;
      ld_lead = 1'b0;
      ld_lag  = 1'b0;
      dec     = 1'b0;
      capture = 1'b0;
      finish  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d    = ST_LEAD;
               ld_lead = 1'b1;
               capture = 1'b1;
            end
         end
         ST_LEAD: begin
            if (cnt_zero) st_d = ST_ACTIVE;
            else          dec  = 1'b1;
         end
         ST_ACTIVE: begin
            if (stop) begin
               st_d   = ST_LAG;
               ld_lag = 1'b1;
            end
         end
         ST_LAG: begin
            if (cnt_zero) begin
               st_d   = ST_IDLE;
               finish = 1'b1;
            end else begin
               dec = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cs_q        <= 1'b0;
         strobe_on_q <= 1'b0;
         ready_q     <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         st_q        <= st_d;
         cs_q        <= (st_d != ST_IDLE);
         strobe_on_q <= (st_d == ST_ACTIVE) && gate;
         ready_q     <= (st_d == ST_ACTIVE);
         done_q      <= finish;
      end
   end

   assign cs_active = cs_q;
   assign strobe_n  = ~strobe_on_q;
   assign ready     = ready_q;
   assign done      = done_q;

   AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> cs_active); // R9
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cs_active && $past(cs_active)); // R5
   AST_STROBE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> ready); // R3

endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen #(
   parameter int CS_W      = 7,
   parameter int SEL_W     = 2,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xfer_start,
   input  logic            xfer_stop,
   input  logic [6:0]      cs_code_in,
   input  logic [1:0]      lead_sel,
   input  logic [1:0]      lag_sel,
   input  logic            strobe_en,
   input  logic            master_mode,
   input  logic            cont_clk,
   output logic [6:0]      cs_code_out,
   output logic            cs_active,
   output logic            strobe_n,
   output logic            strobe_ready,
   output logic            release_done
);
   localparam int CNT_W = SEL_W + 1;

   initial begin
      assert (CS_W == 7)
         else $error("cs_strobe_gen: CS_W must match the 7-bit code ports");
      assert (SEL_W == 2)
         else $error("cs_strobe_gen: SEL_W must match the 2-bit field ports");
   end

   logic [CS_W-1:0]  code_q;
   logic [SEL_W-1:0] lag_sel_q;
   logic             gate_q;
   logic [CNT_W-1:0] lead_reload, lag_reload, load_val;
   logic             ld_lead, ld_lag, dec, capture, finish, cnt_zero;

   cssg_sel_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W), .USE_TABLE(USE_TABLE)) u_lead_dec (
      .sel    (lead_sel),
      .reload (lead_reload)
   );

   cssg_sel_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W), .USE_TABLE(USE_TABLE)) u_lag_dec (
      .sel    (lag_sel_q),
      .reload (lag_reload)
   );

   assign load_val = ld_lag ? lag_reload : lead_reload;

   cssg_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_lead | ld_lag),
      .load_val (load_val),
      .dec      (dec),
      .zero     (cnt_zero)
   );

   cssg_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (xfer_start),
      .stop      (xfer_stop),
      .cnt_zero  (cnt_zero),
      .gate      (gate_q),
      .ld_lead   (ld_lead),
      .ld_lag    (ld_lag),
      .dec       (dec),
      .capture   (capture),
      .finish    (finish),
      .cs_active (cs_active),
      .strobe_n  (strobe_n),
      .ready     (strobe_ready),
      .done      (release_done)
   );

   // Transfer context captured once per transfer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= '0;
         lag_sel_q <= '0;
         gate_q    <= 1'b0;
      end else if (capture) begin
         code_q    <= cs_code_in;
         lag_sel_q <= lag_sel;
         gate_q    <= master_mode & strobe_en & ~cont_clk;
      end else if (finish) begin
         code_q    <= '0;
      end
   end

   assign cs_code_out = code_q;

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && $past(cs_active)) |-> $stable(cs_code_out)); // R6
   AST_STOP_DROPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_ready && xfer_stop) |=> strobe_n && !strobe_ready && cs_active); // R4
   AST_START_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_active && xfer_start) |=> cs_active && (cs_code_out == $past(cs_code_in))); // R2

endmodule

// File: tb/cs_strobe_gen_test.sv
module cs_strobe_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_start = 1'b0, xfer_stop = 1'b0;
   logic [6:0] cs_code_in = '0;
   logic [1:0] lead_sel = '0, lag_sel = '0;
   logic       strobe_en = 1'b0, master_mode = 1'b0, cont_clk = 1'b0;
   logic [6:0] cs_code_out;
   logic       cs_active, strobe_n, strobe_ready, release_done;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   cs_strobe_gen uut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
      .cs_code_in(cs_code_in), .lead_sel(lead_sel), .lag_sel(lag_sel),
      .strobe_en(strobe_en), .master_mode(master_mode), .cont_clk(cont_clk),
      .cs_code_out(cs_code_out), .cs_active(cs_active), .strobe_n(strobe_n),
      .strobe_ready(strobe_ready), .release_done(release_done)
   );

   function automatic int exp_len(input logic [1:0] f);
      case (f)
         2'b00:   return 1;
         2'b01:   return 3;
         2'b10:   return 5;
         default: return 7;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [6:0] code, input logic [1:0] ld, input logic [1:0] lg,
                           input logic en, input logic mm, input logic cc,
                           input int hold, input bit noisy);
      int n, m;
      bit g;
      n = exp_len(ld);
      m = exp_len(lg);
      g = en && mm && !cc;
      cs_code_in = code; lead_sel = ld; lag_sel = lg;
      strobe_en = en; master_mode = mm; cont_clk = cc;
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      chk("R2", "cs_active after start", int'(cs_active), 1);
      chk("R2", "code latched", int'(cs_code_out), int'(code));
      chk("R3", "strobe_n at lead start", int'(strobe_n), 1);
      for (int k = 1; k <= n; k++) begin
         if (noisy) begin
            cs_code_in = 7'($urandom);
            xfer_start = 1'($urandom);           // R8: ignored mid-transfer
            xfer_stop  = (k < n) ? 1'($urandom) : 1'b0; // R8: ignored before ready
            lead_sel = 2'($urandom); lag_sel = 2'($urandom);
            strobe_en = 1'($urandom); master_mode = 1'($urandom); cont_clk = 1'($urandom);
         end
         @(negedge clk);
         chk("R3", "strobe_ready during lead", int'(strobe_ready), (k >= n) ? 1 : 0);
         chk("R7", "strobe_n during lead", int'(strobe_n), (k >= n && g) ? 0 : 1);
         chk("R6", "code held in lead", int'(cs_code_out), int'(code));
      end
      xfer_stop = 1'b0;
      for (int h = 0; h < hold; h++) begin
         if (noisy) begin
            cs_code_in = 7'($urandom);
            xfer_start = 1'($urandom);
         end
         @(negedge clk);
         chk("R8", "still active", int'(strobe_ready), 1);
         chk("R6", "code held active", int'(cs_code_out), int'(code));
      end
      xfer_start = 1'b0;
      xfer_stop = 1'b1;
      @(negedge clk);
      xfer_stop = 1'b0;
      chk("R4", "strobe_n after stop", int'(strobe_n), 1);
      chk("R4", "ready after stop", int'(strobe_ready), 0);
      chk("R9", "cs held after strobe release", int'(cs_active), 1);
      for (int k = 1; k <= m; k++) begin
         if (noisy) cs_code_in = 7'($urandom);
         @(negedge clk);
         chk("R4", "cs_active during lag", int'(cs_active), (k < m) ? 1 : 0);
         chk("R5", "release_done", int'(release_done), (k == m) ? 1 : 0);
         chk("R5", "code out", int'(cs_code_out), (k == m) ? 0 : int'(code));
      end
      @(negedge clk);
      chk("R5", "release_done one cycle", int'(release_done), 0);
      chk("R8", "idle after release", int'(cs_active), 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1", "strobe_n reset", int'(strobe_n), 1);
      chk("R1", "cs_active reset", int'(cs_active), 0);
      chk("R1", "code reset", int'(cs_code_out), 0);
      chk("R1", "ready reset", int'(strobe_ready), 0);
      chk("R1", "done reset", int'(release_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: stop while idle does nothing
      xfer_stop = 1'b1;
      @(negedge clk);
      xfer_stop = 1'b0;
      chk("R8", "stop in idle", int'(cs_active), 0);
      // directed: every prescaler value with gating on
      for (int s = 0; s < 4; s++)
         run_xfer(7'(s * 37 + 5), 2'(s), 2'(3 - s), 1'b1, 1'b1, 1'b0, 2, 1'b0);
      // directed R7: each gating input blocking the strobe
      run_xfer(7'h7F, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1, 1'b0);
      run_xfer(7'h40, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1, 1'b0);
      run_xfer(7'h01, 2'b11, 2'b10, 1'b1, 1'b1, 1'b1, 1, 1'b0);
      // back-to-back minimum transfers
      run_xfer(7'h2A, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 0, 1'b0);
      run_xfer(7'h55, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      // random
      for (int r = 0; r < 40; r++) begin
         logic [2:0] gsel;
         gsel = 3'($urandom);
         run_xfer(7'($urandom), 2'($urandom), 2'($urandom),
                  gsel != 3'd1, gsel != 3'd2, gsel == 3'd3,
                  int'($urandom % 4), 1'b1);
      end
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule